// File: doc/BRIEF.md
# SD Host Register Block

This block is the software-visible register file of an SD/MMC host controller. A processor reaches it through a plain 32-bit register bus with byte offsets. It holds the command word, the command argument, the four response words and the index of the command that responded. It also holds data-path setup (block size exponent, direction, DMA request, data enable), the data timer and the data length, plus sticky event status with a write-one-to-clear register, an interrupt mask, and constant feature and revision words.

The card-side command and data engines are outside the block. They report events on a set-pulse vector and load responses through a strobe. In return they receive a one-cycle command-start strobe, a one-cycle data-start strobe, and the current command and data settings. A single interrupt line is raised while any status event bit is set and enabled in the mask. Setting the reset bit of the command word returns the whole register set to its reset values, and the bit never reads back as one. The power, clock, bus-width and data-window offsets belong to other parts of the controller and read as zero here.

Top module: `sdhost_regs`

## Requirements
- R1: After reset every mapped register reads zero except the feature word and the revision word, and `irq` is low.
- R2: Status (offset 0x28) bits 10:0 are sticky. A one on `ev_set[i]` sets bit i, and the bit stays set until it is cleared. Bit 0 is response CRC fail, bit 1 data CRC fail, bit 2 response timeout, bit 3 data timeout, bit 4 response CRC good, bit 5 data CRC good, bit 6 command sent, bit 7 data end, bit 8 FIFO underrun, bit 9 FIFO overrun and bit 10 card change. Bit 11 shows `card_present` live, bit 12 shows `write_lock` live, and the upper bits read zero.
- R3: Writing the clear register (offset 0x2C) clears each status bit 10:0 whose data bit is one. If an event and a clear hit the same bit in the same cycle, the bit stays set. The clear register reads zero.
- R4: The interrupt mask (offset 0x30, bits 10:0) reads back as written. `irq` is high exactly when some status bit 10:0 and its mask bit are both one, one cycle after the event or write that causes it.
- R5: The command word (offset 0x00) holds bits 9:0: bits 5:0 index, bit 6 response expected, bit 7 long response, bit 8 application command, bit 9 enable. These fields drive `cmd_index`, `cmd_rsp_en`, `cmd_long`, `cmd_app`. A write with bit 9 set and bit 10 clear gives `cmd_start` high for exactly the next cycle. A write with bit 9 clear gives no strobe.
- R6: Data control (offset 0x1C) holds bits 3:0 block size exponent, bit 4 write direction, bit 5 DMA enable and bit 6 data enable. Bit 6 stays pending until an `ev_set[6]` (command sent) pulse. `data_start` is then high for the single cycle that follows the pulse, and bit 6 reads zero from then on.
- R7: A command-word write with bit 10 set returns every register, status bit, mask bit and pending flag to its reset value in the next cycle, with no `cmd_start`. The data timer and the command word then read zero.
- R8: A `rsp_load` pulse captures `rsp_data[31:0]`, `[63:32]`, `[95:64]` and `[127:96]` into offsets 0x08, 0x0C, 0x10 and 0x14, and `rsp_idx` into offset 0x18 (bits 6:0).
- R9: The feature word (offset 0x44) reads FIFO depth in words in bits 7:0 and the content-protection option in bit 8. The revision word (offset 0x48) reads major in bits 31:16, minor in 15:8 and patch in 7:0.
- R10: Unmapped offsets read zero. Writes to status, responses, responded command, feature and revision change nothing.
- R11: The argument (0x04), data timer (0x20) and data length (0x24) read back as written and drive `cmd_arg`, `data_timer` and `data_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_sel | input | 1 | Register access valid |
| bus_wr | input | 1 | Access is a write |
| bus_addr | input | AW | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| ev_set | input | 11 | Status set pulses, one per sticky bit |
| card_present | input | 1 | Live card presence |
| write_lock | input | 1 | Live write-protect state |
| rsp_load | input | 1 | Response capture strobe |
| rsp_data | input | 128 | Response words, word 0 lowest |
| rsp_idx | input | 7 | Responded command index and application flag |
| cmd_start | output | 1 | One-cycle command start |
| cmd_index | output | 6 | Command index |
| cmd_rsp_en | output | 1 | Response expected |
| cmd_long | output | 1 | Long response |
| cmd_app | output | 1 | Application command |
| cmd_arg | output | 32 | Command argument |
| data_start | output | 1 | One-cycle data start |
| data_blk_log2 | output | 4 | Block size exponent |
| data_write | output | 1 | Write direction |
| data_dma | output | 1 | DMA enable |
| data_timer | output | 32 | Data timer value |
| data_len | output | 32 | Data length |
| irq | output | 1 | Interrupt |

## Verification
Reads are combinational, so a register changed at a clock edge is read in the next half-cycle, sampled one time unit after the falling edge. `irq` and the status word follow an event or clear after one edge. `cmd_start` is due in the cycle after the command write, and `data_start` in the cycle after the command-sent pulse. The bench checks each strobe in its due cycle and again one cycle later to confirm that it fell. Random event, clear and mask traffic is checked after every single edge against a bench model of the sticky bits.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
   // word indices (byte offset / 4)
   localparam int W_CMD  = 0;
   localparam int W_ARG  = 1;
   localparam int W_RSP0 = 2;
   localparam int W_RSP1 = 3;
   localparam int W_RSP2 = 4;
   localparam int W_RSP3 = 5;
   localparam int W_RCMD = 6;
   localparam int W_DCTL = 7;
   localparam int W_DTMR = 8;
   localparam int W_DLEN = 9;
   localparam int W_STAT = 10;
   localparam int W_CLR  = 11;
   localparam int W_MASK = 12;
   localparam int W_FEAT = 17;
   localparam int W_REV  = 18;

   localparam int EVT_BITS     = 11;
   localparam int CMD_SENT_BIT = 6;
   localparam int CMD_GO_BIT   = 9;
   localparam int CMD_RST_BIT  = 10;
   localparam int DCTL_EN_BIT  = 6;
endpackage

// File: rtl/sdh_status.sv
module sdh_status #(
   parameter int N = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         soft_clr,
   input  logic [N-1:0] ev_set,
   input  logic         clr_we,
   input  logic [N-1:0] clr_bits,
   input  logic         mask_we,
   input  logic [N-1:0] mask_bits,
   output logic [N-1:0] st_q,
   output logic [N-1:0] mask_q,
   output logic         irq
);
   if (N < 1 || N > 32) begin : g_bad_n
      $error("sdh_status: N out of range");
   end

   logic [N-1:0] st_d;

   for (genvar i = 0; i < N; i++) begin : g_bit
      // set has priority over clear
      assign st_d[i] = ev_set[i] | (st_q[i] & ~(clr_we & clr_bits[i]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || soft_clr) begin
         st_q   <= '0;
         mask_q <= '0;
      end else begin
         st_q <= st_d;
         if (mask_we) mask_q <= mask_bits;
      end
   end

   assign irq = |(st_q & mask_q);

   // R2: a set bit is held while no clear is written
   a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_clr && !clr_we) |=> ((st_q & $past(st_q)) == $past(st_q)));
   // R3: an event always lands, even against a clear
   a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      !soft_clr |=> ((st_q & $past(ev_set)) == $past(ev_set)));
   // R4: nothing masked in means no interrupt
   a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq);
   // R7: soft reset empties the status
   a_r7_status_empty: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> (st_q == '0 && mask_q == '0));
endmodule

// File: rtl/sdh_seq.sv
module sdh_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_clr,
   input  logic cmd_go,
   input  logic den_wr,
   input  logic den_val,
   input  logic cmd_sent,
   output logic cmd_start,
   output logic data_start,
   output logic data_pend
);
   always_ff @(posedge clk) begin
      if (!rst_n || soft_clr) begin
         cmd_start  <= 1'b0;
         data_start <= 1'b0;
         data_pend  <= 1'b0;
      end else begin
         cmd_start  <= cmd_go;
         data_start <= 1'b0;
         if (den_wr) begin
            data_pend <= den_val;
         end else if (data_pend && cmd_sent) begin
            data_pend  <= 1'b0;
            data_start <= 1'b1;
         end
      end
   end

   // R5: command strobe lasts one cycle
   a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |=> !cmd_start);
   // R6: data only starts right after a command-sent event
   a_r6_data_after_sent: assert property (@(posedge clk) disable iff (!rst_n)
      data_start |-> ($past(cmd_sent) && !data_pend));
endmodule

// File: rtl/sdhost_regs.sv
module sdhost_regs
   import sdh_pkg::*;
#(
   parameter int          AW         = 8,
   parameter int          FIFO_WORDS = 16,
   parameter bit          CPRM_EN    = 1'b0,
   parameter logic [15:0] REV_MAJOR  = 16'h0001,
   parameter logic [7:0]  REV_MINOR  = 8'h02,
   parameter logic [7:0]  REV_PATCH  = 8'h03
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_sel,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [31:0]   bus_wdata,
   output logic [31:0]   bus_rdata,
   input  logic [10:0]   ev_set,
   input  logic          card_present,
   input  logic          write_lock,
   input  logic          rsp_load,
   input  logic [127:0]  rsp_data,
   input  logic [6:0]    rsp_idx,
   output logic          cmd_start,
   output logic [5:0]    cmd_index,
   output logic          cmd_rsp_en,
   output logic          cmd_long,
   output logic          cmd_app,
   output logic [31:0]   cmd_arg,
   output logic          data_start,
   output logic [3:0]    data_blk_log2,
   output logic          data_write,
   output logic          data_dma,
   output logic [31:0]   data_timer,
   output logic [31:0]   data_len,
   output logic          irq
);
   localparam int IW = AW - 2;
   localparam logic [31:0] FEAT_WORD = {23'd0, CPRM_EN, 8'(FIFO_WORDS)};
   localparam logic [31:0] REV_WORD  = {REV_MAJOR, REV_MINOR, REV_PATCH};

   if (AW < 7) begin : g_bad_aw
      $error("sdhost_regs: AW too small for the register map");
   end
   if (FIFO_WORDS < 1 || FIFO_WORDS > 255) begin : g_bad_fifo
      $error("sdhost_regs: FIFO_WORDS must fit in 8 bits");
   end

   logic          we;
   logic [IW-1:0] widx;
   logic          hit_cmd, hit_arg, hit_dctl, hit_dtmr, hit_dlen, hit_clr, hit_mask;
   logic          soft_clr;
   logic          unused_addr;

   assign we          = bus_sel & bus_wr;
   assign widx        = bus_addr[AW-1:2];
   assign unused_addr = ^bus_addr[1:0];
   assign hit_cmd     = we && (widx == IW'(W_CMD));
   assign hit_arg     = we && (widx == IW'(W_ARG));
   assign hit_dctl    = we && (widx == IW'(W_DCTL));
   assign hit_dtmr    = we && (widx == IW'(W_DTMR));
   assign hit_dlen    = we && (widx == IW'(W_DLEN));
   assign hit_clr     = we && (widx == IW'(W_CLR));
   assign hit_mask    = we && (widx == IW'(W_MASK));
   assign soft_clr    = hit_cmd && bus_wdata[CMD_RST_BIT];

   logic [9:0]        cmd_q;
   logic [31:0]       arg_q, dtmr_q, dlen_q;
   logic [3:0][31:0]  rsp_q;
   logic [6:0]        rcmd_q;
   logic [5:0]        dctl_q;
   logic              data_pend;
   logic [EVT_BITS-1:0] st_q, mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n || soft_clr) begin
         cmd_q  <= '0;
         arg_q  <= '0;
         dtmr_q <= '0;
         dlen_q <= '0;
         rsp_q  <= '0;
         rcmd_q <= '0;
         dctl_q <= '0;
      end else begin
         if (hit_cmd)  cmd_q  <= bus_wdata[9:0];
         if (hit_arg)  arg_q  <= bus_wdata;
         if (hit_dtmr) dtmr_q <= bus_wdata;
         if (hit_dlen) dlen_q <= bus_wdata;
         if (hit_dctl) dctl_q <= bus_wdata[5:0];
         if (rsp_load) begin
            rsp_q  <= rsp_data;
            rcmd_q <= rsp_idx;
         end
      end
   end

   sdh_status #(.N(EVT_BITS)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_clr  (soft_clr),
      .ev_set    (ev_set),
      .clr_we    (hit_clr),
      .clr_bits  (bus_wdata[EVT_BITS-1:0]),
      .mask_we   (hit_mask),
      .mask_bits (bus_wdata[EVT_BITS-1:0]),
      .st_q      (st_q),
      .mask_q    (mask_q),
      .irq       (irq)
   );

   sdh_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_clr   (soft_clr),
      .cmd_go     (hit_cmd && bus_wdata[CMD_GO_BIT] && !bus_wdata[CMD_RST_BIT]),
      .den_wr     (hit_dctl),
      .den_val    (bus_wdata[DCTL_EN_BIT]),
      .cmd_sent   (ev_set[CMD_SENT_BIT]),
      .cmd_start  (cmd_start),
      .data_start (data_start),
      .data_pend  (data_pend)
   );

   always_comb begin
      bus_rdata = '0;
      case (widx)
         IW'(W_CMD):  bus_rdata = {22'd0, cmd_q};
         IW'(W_ARG):  bus_rdata = arg_q;
         IW'(W_RSP0): bus_rdata = rsp_q[0];
         IW'(W_RSP1): bus_rdata = rsp_q[1];
         IW'(W_RSP2): bus_rdata = rsp_q[2];
         IW'(W_RSP3): bus_rdata = rsp_q[3];
         IW'(W_RCMD): bus_rdata = {25'd0, rcmd_q};
         IW'(W_DCTL): bus_rdata = {25'd0, data_pend, dctl_q};
         IW'(W_DTMR): bus_rdata = dtmr_q;
         IW'(W_DLEN): bus_rdata = dlen_q;
         IW'(W_STAT): bus_rdata = {19'd0, write_lock, card_present, st_q};
         IW'(W_MASK): bus_rdata = {21'd0, mask_q};
         IW'(W_FEAT): bus_rdata = FEAT_WORD;
         IW'(W_REV):  bus_rdata = REV_WORD;
         default:     bus_rdata = '0;
      endcase
   end

   assign cmd_index     = cmd_q[5:0];
   assign cmd_rsp_en    = cmd_q[6];
   assign cmd_long      = cmd_q[7];
   assign cmd_app       = cmd_q[8];
   assign cmd_arg       = arg_q;
   assign data_blk_log2 = dctl_q[3:0];
   assign data_write    = dctl_q[4];
   assign data_dma      = dctl_q[5];
   assign data_timer    = dtmr_q;
   assign data_len      = dlen_q;

   // R7: soft reset leaves command word and timer at zero
   a_r7_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> (cmd_q == '0 && dtmr_q == '0 && !cmd_start));
   // R8: response word 0 captured on load
   a_r8_rsp_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_load && !soft_clr) |=> (rsp_q[0] == $past(rsp_data[31:0])));
   // R10: responses hold when not loaded
   a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!rsp_load && !soft_clr) |=> $stable(rsp_q));
endmodule

// File: tb/sdhost_regs_tb.sv
module sdhost_regs_tb;
   localparam int PERIOD = 10;
   localparam logic [31:0] FEAT_EXP = 32'h0000_0010;
   localparam logic [31:0] REV_EXP  = 32'h0001_0203;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]   bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic [10:0]  ev_set = '0;
   logic         card_present = 1'b0, write_lock = 1'b0;
   logic         rsp_load = 1'b0;
   logic [127:0] rsp_data = '0;
   logic [6:0]   rsp_idx = '0;
   logic         cmd_start, cmd_rsp_en, cmd_long, cmd_app, data_start;
   logic         data_write, data_dma, irq;
   logic [5:0]   cmd_index;
   logic [3:0]   data_blk_log2;
   logic [31:0]  cmd_arg, data_timer, data_len;

   int checks = 0;
   int errors = 0;

   sdhost_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ev_set(ev_set), .card_present(card_present), .write_lock(write_lock),
      .rsp_load(rsp_load), .rsp_data(rsp_data), .rsp_idx(rsp_idx),
      .cmd_start(cmd_start), .cmd_index(cmd_index), .cmd_rsp_en(cmd_rsp_en),
      .cmd_long(cmd_long), .cmd_app(cmd_app), .cmd_arg(cmd_arg),
      .data_start(data_start), .data_blk_log2(data_blk_log2),
      .data_write(data_write), .data_dma(data_dma), .data_timer(data_timer),
      .data_len(data_len), .irq(irq)
   );

   always #(PERIOD/2) clk = ~clk;

   function automatic logic [31:0] exp_stat(logic [10:0] st, logic cd, logic wp);
      return {19'd0, wp, cd, st};
   endfunction

   function automatic logic exp_irq(logic [10:0] st, logic [10:0] m);
      return |(st & m);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %08h expected %08h", req, act, exp);
      end
   endtask

   // one-cycle write, returns at the next falling edge with bus idle
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      @(negedge clk);
      rd(a, v);
      check(req, v, exp);
   endtask

   initial begin
      #(PERIOD*100000);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [10:0] m_st, m_mask;
      logic [31:0] v;
      void'($urandom(32'd4711));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values of the whole map
      for (int i = 0; i < 21; i++) begin
         rd_check("R1", 8'(i*4), (i == 17) ? FEAT_EXP : (i == 18) ? REV_EXP : 32'd0);
      end
      check("R1 irq", {31'd0, irq}, 32'd0);
      // R9: feature and revision fields
      rd_check("R9 feature", 8'h44, FEAT_EXP);
      rd_check("R9 revision", 8'h48, REV_EXP);

      // R11: read/write registers drive outputs
      wr(8'h04, 32'hDEAD_BEEF);
      wr(8'h20, 32'h0012_3456);
      wr(8'h24, 32'h0000_0200);
      rd_check("R11 arg", 8'h04, 32'hDEAD_BEEF);
      rd_check("R11 timer", 8'h20, 32'h0012_3456);
      rd_check("R11 len", 8'h24, 32'h0000_0200);
      check("R11 arg out", cmd_arg, 32'hDEAD_BEEF);
      check("R11 timer out", data_timer, 32'h0012_3456);
      check("R11 len out", data_len, 32'h0000_0200);

      // R10: unmapped reads and read-only writes
      rd_check("R10 unmapped 34", 8'h34, 32'd0);
      rd_check("R10 unmapped 40", 8'h40, 32'd0);
      rd_check("R10 unmapped fc", 8'hFC, 32'd0);
      wr(8'h44, 32'hFFFF_FFFF);
      wr(8'h48, 32'hFFFF_FFFF);
      wr(8'h28, 32'hFFFF_FFFF);
      wr(8'h08, 32'hFFFF_FFFF);
      wr(8'h18, 32'hFFFF_FFFF);
      rd_check("R10 feature ro", 8'h44, FEAT_EXP);
      rd_check("R10 revision ro", 8'h48, REV_EXP);
      rd_check("R10 status ro", 8'h28, 32'd0);
      rd_check("R10 rsp ro", 8'h08, 32'd0);
      rd_check("R10 rcmd ro", 8'h18, 32'd0);
      rd_check("R3 clear reads zero", 8'h2C, 32'd0);

      // R8: response capture
      @(negedge clk);
      rsp_data = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
      rsp_idx = 7'h4D; rsp_load = 1'b1;
      @(negedge clk);
      rsp_load = 1'b0;
      rd_check("R8 rsp0", 8'h08, 32'h1111_1111);
      rd_check("R8 rsp1", 8'h0C, 32'h2222_2222);
      rd_check("R8 rsp2", 8'h10, 32'h3333_3333);
      rd_check("R8 rsp3", 8'h14, 32'h4444_4444);
      rd_check("R8 rcmd", 8'h18, 32'h0000_004D);

      // R5: command strobe and fields
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h0000_02C5;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      #1 check("R5 start high", {31'd0, cmd_start}, 32'd1);
      @(negedge clk);
      #1 check("R5 start low", {31'd0, cmd_start}, 32'd0);
      check("R5 fields", {22'd0, cmd_app, cmd_long, cmd_rsp_en, cmd_index},
            {22'd0, 1'b0, 1'b1, 1'b1, 6'd5});
      rd_check("R5 readback", 8'h00, 32'h0000_02C5);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h0000_0145;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      #1 check("R5 no start without enable", {31'd0, cmd_start}, 32'd0);
      check("R5 app flag", {31'd0, cmd_app}, 32'd1);

      // R6: pending data enable
      wr(8'h1C, 32'h0000_0059);
      rd_check("R6 pending", 8'h1C, 32'h0000_0059);
      check("R6 outputs", {24'd0, data_dma, data_write, data_blk_log2}, 32'h0000_0019);
      check("R6 no early start", {31'd0, data_start}, 32'd0);
      @(negedge clk);
      ev_set = 11'h040;
      @(negedge clk);
      ev_set = '0;
      #1 check("R6 data start", {31'd0, data_start}, 32'd1);
      @(negedge clk);
      #1 check("R6 start falls", {31'd0, data_start}, 32'd0);
      rd_check("R6 enable cleared", 8'h1C, 32'h0000_0019);
      rd_check("R2 cmd sent bit", 8'h28, 32'h0000_0040);

      // R3: set wins over simultaneous clear
      wr(8'h2C, 32'h0000_07FF);
      @(negedge clk);
      ev_set = 11'h001;
      @(negedge clk);
      ev_set = 11'h003;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h2C; bus_wdata = 32'h0000_0003;
      @(negedge clk);
      ev_set = '0; bus_sel = 1'b0; bus_wr = 1'b0;
      rd(8'h28, v);
      check("R3 set wins", v, 32'h0000_0003);
      wr(8'h2C, 32'h0000_0002);
      rd_check("R3 selective clear", 8'h28, 32'h0000_0001);
      wr(8'h2C, 32'h0000_0001);

      // R2/R3/R4: random events, clears and mask writes
      m_st = '0; m_mask = '0;
      for (int it = 0; it < 300; it++) begin
         logic [31:0] rw;
         int unsigned kind;
         @(negedge clk);
         rw = $urandom;
         kind = $urandom_range(0, 3);
         ev_set = 11'($urandom) & 11'($urandom) & 11'($urandom);
         card_present = 1'($urandom);
         write_lock = 1'($urandom);
         if (kind == 0) begin
            bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h2C; bus_wdata = rw;
            m_st = ev_set | (m_st & ~rw[10:0]);
         end else if (kind == 1) begin
            bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h30; bus_wdata = rw;
            m_mask = rw[10:0];
            m_st = m_st | ev_set;
         end else begin
            m_st = m_st | ev_set;
         end
         @(negedge clk);
         ev_set = '0; bus_sel = 1'b0; bus_wr = 1'b0;
         rd(8'h28, v);
         check("R2 status", v, exp_stat(m_st, card_present, write_lock));
         check("R4 irq", {31'd0, irq}, {31'd0, exp_irq(m_st, m_mask)});
         if (kind == 1) begin
            rd(8'h30, v);
            check("R4 mask readback", v, {21'd0, m_mask});
         end
      end
      card_present = 1'b0; write_lock = 1'b0;

      // R7: soft reset
      wr(8'h30, 32'h0000_07FF);
      @(negedge clk);
      ev_set = 11'h010;
      @(negedge clk);
      ev_set = '0;
      wr(8'h1C, 32'h0000_0040);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h0000_0600;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      #1 check("R7 no strobe", {31'd0, cmd_start}, 32'd0);
      check("R7 irq low", {31'd0, irq}, 32'd0);
      rd_check("R7 cmd zero", 8'h00, 32'd0);
      rd_check("R7 arg zero", 8'h04, 32'd0);
      rd_check("R7 timer zero", 8'h20, 32'd0);
      rd_check("R7 len zero", 8'h24, 32'd0);
      rd_check("R7 dctl zero", 8'h1C, 32'd0);
      rd_check("R7 status zero", 8'h28, 32'd0);
      rd_check("R7 mask zero", 8'h30, 32'd0);
      rd_check("R7 rsp zero", 8'h08, 32'd0);
      @(negedge clk);
      ev_set = 11'h040;
      @(negedge clk);
      ev_set = '0;
      #1 check("R7 pending dropped", {31'd0, data_start}, 32'd0);
      rd_check("R7 feature kept", 8'h44, FEAT_EXP);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule